// File: doc/BRIEF.md
# Dual-Edge Parallel Memory Slave

This block is a byte-wide memory and I/O target for a host that shares one 8-bit bus for addresses and data. A 3-bit operation code selects one of eight fixed operations, and a single strobe line paces the transfer. Every change of the strobe, whether it rises or falls, is one transfer cycle. On that cycle the block either takes the byte the host presents or presents the byte the host asked for. There is no start or resynchronisation signal. Host and block stay in step only by counting strobe transitions from reset.

Inside the block are a byte memory, a 16-bit program counter, a 16-bit stack pointer and a small file of port registers. These support random reads and writes, port accesses, sequential instruction fetch, push, pop and jump. The stack pointer is loaded through two reserved port numbers. The strobe and the operation code pass through a two-flop synchroniser into the block's clock. The bus is split into an input byte and an output byte with an output enable. The enable is high only while the block is supplying read data.

Top module: `strobe_mem_slave`

## Requirements
- R1: Every strobe transition, in either direction, advances the transfer by exactly one cycle. Changes on the operation code or bus lines without a strobe transition have no effect on any state or output.
- R2: Operation code 0 (read) takes three cycles: address low byte, address high byte, then the block returns the addressed memory byte. Operation code 1 (write) takes three cycles: address low byte, address high byte, then the data byte, which is stored.
- R3: Operation code 3 (port write) takes two cycles: port number, then the data byte. Operation code 2 (port read) takes two cycles: port number, then the block returns that port's value. Ports other than 0xFE and 0xFF select a register by the low PORT_AW bits of the port number (8 registers by default). These registers read as 0 after reset.
- R4: Operation code 4 takes one cycle. It returns the memory byte at the program counter, then increments the counter.
- R5: Operation code 5 (pop) takes one cycle. It returns the memory byte at the stack pointer, then increments the pointer.
- R6: Operation code 6 (push) takes one cycle. It first decrements the stack pointer, then stores the bus byte at the new pointer.
- R7: Operation code 7 (jump) takes three cycles, like a read. It returns the byte at the supplied address and loads the program counter with that address plus one.
- R8: A port write to 0xFE sets the stack pointer's low byte and one to 0xFF sets its high byte. Port reads of 0xFE and 0xFF return those bytes.
- R9: The output enable rises on the strobe cycle that returns data and stays high until the next strobe cycle. It is low after every other cycle. The new output appears on the third rising clock edge after the strobe transition.
- R10: Synchronous reset clears the cycle position, the program counter, the stack pointer and the output enable.
- R11: Addresses, the program counter and the stack pointer are 16 bits and wrap modulo 65536. The memory holds 2^MEM_AW bytes and is indexed by the address modulo that depth.
- R12: The operation code is sampled only on the first cycle of an operation. Its value on the later cycles of a multi-cycle operation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_in | input | 1 | Transfer strobe; each transition is one cycle |
| op_in | input | 3 | Operation code, sampled on an operation's first cycle |
| bus_in | input | 8 | Address or data byte from the host |
| bus_out | output | 8 | Read data returned to the host |
| bus_oe | output | 1 | High while bus_out carries requested data |

## Verification
The assertions assume three things about the host. It holds the operation code and bus byte stable from one strobe transition until the next. It leaves at least three clock periods between transitions, so that each transition is seen once after synchronisation. The strobe rests low through reset. The stimulus changes op_in, bus_in and strobe_in together on a falling clock edge and spaces transitions three and a half clocks apart. It moves op_in and bus_in freely only during deliberate idle stretches, when the strobe is left alone.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [2:0] {
    OP_RD    = 3'd0,
    OP_WR    = 3'd1,
    OP_PRD   = 3'd2,
    OP_PWR   = 3'd3,
    OP_FETCH = 3'd4,
    OP_POP   = 3'd5,
    OP_PUSH  = 3'd6,
    OP_JMP   = 3'd7
  } smem_op_e;

  localparam logic [7:0] SP_LO_PORT = 8'hFE;
  localparam logic [7:0] SP_HI_PORT = 8'hFF;

  // Number of strobe cycles each operation spans.
  function automatic logic [1:0] op_len(input smem_op_e op);
    case (op)
      OP_RD, OP_WR, OP_JMP: op_len = 2'd3;
      OP_PRD, OP_PWR:       op_len = 2'd2;
      default:              op_len = 2'd1;
    endcase
  endfunction

  function automatic logic [1:0] next_phase(input smem_op_e op, input logic [1:0] ph);
    logic [1:0] inc;
    inc = ph + 2'd1;
    next_phase = (inc == op_len(op)) ? 2'd0 : inc;
  endfunction

  // True on the cycle that returns a byte to the host.
  function automatic logic is_data_out(input smem_op_e op, input logic [1:0] ph);
    case (op)
      OP_RD, OP_JMP:     is_data_out = (ph == 2'd2);
      OP_PRD:            is_data_out = (ph == 2'd1);
      OP_FETCH, OP_POP:  is_data_out = 1'b1;
      default:           is_data_out = 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] addr_step(input logic [15:0] a, input logic up);
    addr_step = up ? (a + 16'd1) : (a - 16'd1);
  endfunction

endpackage

// File: rtl/smem_sync.sv
module smem_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] st1_q;
  logic [W-1:0] st2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= d_async;
      st2_q <= st1_q;
    end
  end

  assign d_sync = st2_q;
endmodule

// File: rtl/smem_seq.sv
module smem_seq
  import smem_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe_s,
  input  logic [2:0] op_s,
  output logic       edge_evt,
  output smem_op_e   op_cur,
  output logic [1:0] phase
);
  logic       strobe_q;
  logic [1:0] phase_q;
  smem_op_e   op_q;

  assign edge_evt = strobe_s ^ strobe_q;
  assign op_cur   = (phase_q == 2'd0) ? smem_op_e'(op_s) : op_q;
  assign phase    = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      phase_q  <= 2'd0;
      op_q     <= OP_RD;
    end else begin
      strobe_q <= strobe_s;
      if (edge_evt) begin
        op_q    <= op_cur;
        phase_q <= next_phase(op_cur, phase_q);
      end
    end
  end
endmodule

// File: rtl/smem_mem.sv
module smem_mem #(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        we,
  input  logic [15:0] waddr,
  input  logic [7:0]  wdata,
  input  logic        re,
  input  logic [15:0] raddr,
  output logic [7:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    cells [DEPTH];
  logic [AW-1:0] widx;
  logic [AW-1:0] ridx;

  // Index by address modulo the depth.
  assign widx = AW'({1'b0, waddr} % 17'(DEPTH));
  assign ridx = AW'({1'b0, raddr} % 17'(DEPTH));

  always_ff @(posedge clk) begin
    if (we) cells[widx] <= wdata;
    if (re) rdata <= cells[ridx];
  end
endmodule

// File: rtl/strobe_mem_slave.sv
module strobe_mem_slave
  import smem_pkg::*;
#(
  parameter int MEM_AW  = 10,
  parameter int PORT_AW = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe_in,
  input  logic [2:0] op_in,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_oe
);
  localparam int PORT_CNT = 1 << PORT_AW;

  logic [3:0]  sync_bus;
  logic        strobe_s;
  logic [2:0]  op_s;
  logic        edge_evt;
  smem_op_e    op_cur;
  logic [1:0]  phase;

  logic [7:0]  addr_lo_q, addr_hi_q, port_num_q, port_rd_q;
  logic [15:0] pc_q, sp_q;
  logic        oe_q, sel_port_q;
  logic [7:0]  port_q [PORT_CNT];

  logic [15:0] full_addr, sp_dec, mem_raddr, mem_waddr;
  logic [7:0]  mem_rdata, port_val;
  logic        port_hit;

  // Named events.
  logic fetch_evt, pop_evt, push_evt, jmp_evt;
  logic mem_rd_evt, mem_wr_evt, port_rd_evt, port_wr_evt, rd_evt;
  logic addr_lo_evt, addr_hi_evt, port_num_evt;

  smem_sync #(.W(4)) u_sync (
    .clk(clk), .rst(rst),
    .d_async({op_in, strobe_in}),
    .d_sync(sync_bus)
  );
  assign strobe_s = sync_bus[0];
  assign op_s     = sync_bus[3:1];

  smem_seq u_seq (
    .clk(clk), .rst(rst),
    .strobe_s(strobe_s), .op_s(op_s),
    .edge_evt(edge_evt), .op_cur(op_cur), .phase(phase)
  );

  assign full_addr = {addr_hi_q, addr_lo_q};
  assign sp_dec    = addr_step(sp_q, 1'b0);

  assign fetch_evt    = edge_evt && (op_cur == OP_FETCH);
  assign pop_evt      = edge_evt && (op_cur == OP_POP);
  assign push_evt     = edge_evt && (op_cur == OP_PUSH);
  assign jmp_evt      = edge_evt && (op_cur == OP_JMP) && (phase == 2'd2);
  assign addr_lo_evt  = edge_evt && (op_len(op_cur) == 2'd3) && (phase == 2'd0);
  assign addr_hi_evt  = edge_evt && (op_len(op_cur) == 2'd3) && (phase == 2'd1);
  assign port_num_evt = edge_evt && (op_len(op_cur) == 2'd2) && (phase == 2'd0);
  assign port_rd_evt  = edge_evt && (op_cur == OP_PRD) && (phase == 2'd1);
  assign port_wr_evt  = edge_evt && (op_cur == OP_PWR) && (phase == 2'd1);
  assign rd_evt       = edge_evt && is_data_out(op_cur, phase);
  assign mem_rd_evt   = rd_evt && !port_rd_evt;
  assign mem_wr_evt   = push_evt || (edge_evt && (op_cur == OP_WR) && (phase == 2'd2));

  assign mem_raddr = fetch_evt ? pc_q : (pop_evt ? sp_q : full_addr);
  assign mem_waddr = push_evt ? sp_dec : full_addr;

  smem_mem #(.AW(MEM_AW)) u_mem (
    .clk(clk),
    .we(mem_wr_evt), .waddr(mem_waddr), .wdata(bus_in),
    .re(mem_rd_evt), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  // Port register file; the two stack-pointer ports bypass it.
  assign port_hit = (port_num_q != SP_LO_PORT) && (port_num_q != SP_HI_PORT);

  for (genvar g = 0; g < PORT_CNT; g++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        port_q[g] <= 8'h00;
      end else if (port_wr_evt && port_hit &&
                   (port_num_q[PORT_AW-1:0] == PORT_AW'(g))) begin
        port_q[g] <= bus_in;
      end
    end
  end

  always_comb begin
    if (port_num_q == SP_LO_PORT)      port_val = sp_q[7:0];
    else if (port_num_q == SP_HI_PORT) port_val = sp_q[15:8];
    else                               port_val = port_q[port_num_q[PORT_AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lo_q  <= 8'h00;
      addr_hi_q  <= 8'h00;
      port_num_q <= 8'h00;
      port_rd_q  <= 8'h00;
      pc_q       <= 16'h0000;
      sp_q       <= 16'h0000;
      oe_q       <= 1'b0;
      sel_port_q <= 1'b0;
    end else begin
      if (edge_evt) begin
        oe_q       <= rd_evt;
        sel_port_q <= port_rd_evt;
      end
      if (addr_lo_evt)  addr_lo_q  <= bus_in;
      if (addr_hi_evt)  addr_hi_q  <= bus_in;
      if (port_num_evt) port_num_q <= bus_in;
      if (port_rd_evt)  port_rd_q  <= port_val;

      if (fetch_evt)    pc_q <= addr_step(pc_q, 1'b1);
      else if (jmp_evt) pc_q <= addr_step(full_addr, 1'b1);

      if (pop_evt)       sp_q <= addr_step(sp_q, 1'b1);
      else if (push_evt) sp_q <= sp_dec;
      else if (port_wr_evt && (port_num_q == SP_LO_PORT)) sp_q[7:0]  <= bus_in;
      else if (port_wr_evt && (port_num_q == SP_HI_PORT)) sp_q[15:8] <= bus_in;
    end
  end

  assign bus_oe  = oe_q;
  assign bus_out = sel_port_q ? port_rd_q : mem_rdata;
endmodule

// File: rtl/smem_checker.sv
module smem_checker (
  input logic        clk,
  input logic        rst,
  input logic        edge_evt,
  input logic [1:0]  phase,
  input logic        rd_evt,
  input logic        fetch_evt,
  input logic        pop_evt,
  input logic        push_evt,
  input logic        bus_oe,
  input logic [15:0] pc,
  input logic [15:0] sp
);
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3); // R1

  AST_PC_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(edge_evt) && !$past(rst)) |-> $stable(pc)); // R1

  AST_OE_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> $past(rd_evt)); // R9

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(edge_evt) && !$past(rst)) |-> $stable(bus_oe)); // R9

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(fetch_evt) && !$past(rst)) |-> (pc == $past(pc) + 16'd1)); // R4

  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(pop_evt) && !$past(rst)) |-> (sp == $past(sp) + 16'd1)); // R5

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(push_evt) && !$past(rst)) |-> (sp == $past(sp) - 16'd1)); // R6

  AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fetch_evt, pop_evt, push_evt})); // R1
endmodule

bind strobe_mem_slave smem_checker u_chk (
  .clk(clk), .rst(rst), .edge_evt(edge_evt), .phase(phase), .rd_evt(rd_evt),
  .fetch_evt(fetch_evt), .pop_evt(pop_evt), .push_evt(push_evt),
  .bus_oe(bus_oe), .pc(pc_q), .sp(sp_q)
);

// File: tb/strobe_mem_slave_test.sv
`timescale 1ns/1ps
module strobe_mem_slave_test;
  localparam int MEM_AW = 10;
  localparam int DEPTH  = 1 << MEM_AW;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_in = 1'b0;
  logic [2:0] op_in = 3'd0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe;

  strobe_mem_slave #(.MEM_AW(MEM_AW), .PORT_AW(3)) uut (
    .clk(clk), .rst(rst), .strobe_in(strobe_in), .op_in(op_in),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  // Behavioural reference state.
  logic       exp_oe = 1'b0;
  logic [7:0] exp_data = 8'h00;
  bit         exp_known = 1'b0;
  string      exp_tag = "R10";
  logic [7:0] mref [int];
  logic [7:0] ports_m [8];
  int         pc_m = 0;
  int         sp_m = 0;
  logic [2:0] noise = 3'd0;

  // Every-clock comparison against the reference.
  always @(negedge clk) begin
    if (live && !done) begin
      checks++;
      if (bus_oe !== exp_oe || (exp_oe && exp_known && bus_out !== exp_data)) begin
        fails++;
        $display("FAIL %s per-cycle: oe=%b data=%h expected oe=%b data=%h",
                 exp_tag, bus_oe, bus_out, exp_oe, exp_data);
      end
    end
  end

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic set_exp(input bit oe, input logic [7:0] d, input bit known, input string tag);
    exp_oe = oe; exp_data = d; exp_known = known; exp_tag = tag;
  endtask

  // One strobe transition; returns just after the edge where outputs settle.
  task automatic strobe_edge(input logic [2:0] op, input logic [7:0] b);
    @(negedge clk);
    op_in = op; bus_in = b; strobe_in = ~strobe_in;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic expect_mem(input int a, input string tag);
    int i;
    i = a % DEPTH;
    if (mref.exists(i)) begin
      set_exp(1'b1, mref[i], 1'b1, tag);
      check8(tag, bus_out, mref[i]);
    end else begin
      set_exp(1'b1, 8'h00, 1'b0, tag);
    end
  endtask

  task automatic do_addr(input logic [2:0] op, input int a, input string tag);
    strobe_edge(op, a[7:0]);     set_exp(1'b0, 8'h00, 1'b1, tag);
    strobe_edge(noise, a[15:8]); set_exp(1'b0, 8'h00, 1'b1, tag);
  endtask

  task automatic do_rd(input int a, input string tag);
    do_addr(3'd0, a, tag);
    strobe_edge(noise, 8'h00);
    expect_mem(a, tag);
  endtask

  task automatic do_wr(input int a, input logic [7:0] d, input string tag);
    do_addr(3'd1, a, tag);
    strobe_edge(noise, d); set_exp(1'b0, 8'h00, 1'b1, tag);
    mref[(a & 16'hFFFF) % DEPTH] = d;
  endtask

  task automatic do_jmp(input int a, input string tag);
    do_addr(3'd7, a, tag);
    strobe_edge(noise, 8'h00);
    expect_mem(a, tag);
    pc_m = (a + 1) & 16'hFFFF;
  endtask

  task automatic do_prd(input int p, input string tag);
    logic [7:0] v;
    strobe_edge(3'd2, p[7:0]); set_exp(1'b0, 8'h00, 1'b1, tag);
    strobe_edge(noise, 8'h00);
    if (p == 8'hFE)      v = sp_m[7:0];
    else if (p == 8'hFF) v = sp_m[15:8];
    else                 v = ports_m[p % 8];
    set_exp(1'b1, v, 1'b1, tag);
    check8(tag, bus_out, v);
  endtask

  task automatic do_pwr(input int p, input logic [7:0] d, input string tag);
    strobe_edge(3'd3, p[7:0]); set_exp(1'b0, 8'h00, 1'b1, tag);
    strobe_edge(noise, d);     set_exp(1'b0, 8'h00, 1'b1, tag);
    if (p == 8'hFE)      sp_m = (sp_m & 16'hFF00) | int'(d);
    else if (p == 8'hFF) sp_m = (sp_m & 16'h00FF) | (int'(d) << 8);
    else                 ports_m[p % 8] = d;
  endtask

  task automatic do_fetch(input string tag);
    strobe_edge(3'd4, 8'h00);
    expect_mem(pc_m, tag);
    pc_m = (pc_m + 1) & 16'hFFFF;
  endtask

  task automatic do_pop(input string tag);
    strobe_edge(3'd5, 8'h00);
    expect_mem(sp_m, tag);
    sp_m = (sp_m + 1) & 16'hFFFF;
  endtask

  task automatic do_push(input logic [7:0] d, input string tag);
    strobe_edge(3'd6, d);
    set_exp(1'b0, 8'h00, 1'b1, tag);
    sp_m = (sp_m - 1) & 16'hFFFF;
    mref[sp_m % DEPTH] = d;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) ports_m[i] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check8("R10 oe during reset", {7'b0, bus_oe}, 8'h00);
    rst = 1'b0;
    live = 1'b1;
    @(negedge clk);
    check8("R10 oe after reset", {7'b0, bus_oe}, 8'h00);

    // Reset values of SP and ports.
    do_prd(8'hFE, "R10 sp low");
    do_prd(8'hFF, "R10 sp high");
    do_prd(8'h03, "R3 port reset");

    // Random access and fetch from PC = 0 (R2, R4, R10).
    do_wr(16'h0000, 8'h11, "R2");
    do_wr(16'h0001, 8'h22, "R2");
    do_fetch("R4 R10 pc from zero");
    do_fetch("R4");
    do_wr(16'h0123, 8'h5A, "R2");
    do_wr(16'h0234, 8'hC3, "R2");
    do_rd(16'h0123, "R2");
    do_rd(16'h0234, "R2");

    // Operation code ignored after first cycle (R12).
    noise = 3'd5;
    do_wr(16'h0155, 8'h77, "R12");
    do_rd(16'h0155, "R12");
    noise = 3'd7;
    do_rd(16'h0123, "R12");
    do_prd(8'h03, "R12 port");
    noise = 3'd0;

    // Port register file and aliasing (R3).
    for (int p = 0; p < 8; p++) do_pwr(p, 8'h30 + 8'(p), "R3");
    for (int p = 0; p < 8; p++) do_prd(p, "R3");
    do_pwr(9, 8'hEE, "R3 alias");
    do_prd(1, "R3 alias");

    // Stack pointer via reserved ports, push and pop (R8, R6, R5).
    do_pwr(8'hFE, 8'h10, "R8");
    do_pwr(8'hFF, 8'h02, "R8");
    do_prd(8'hFE, "R8");
    do_prd(8'hFF, "R8");
    do_push(8'hA1, "R6");
    do_push(8'hA2, "R6");
    do_prd(8'hFE, "R6 sp after push");
    do_rd(16'h020F, "R6 first push slot");
    do_pop("R5");
    do_pop("R5");
    do_prd(8'hFE, "R5 sp after pop");

    // Jump then fetch (R7).
    do_wr(16'h0300, 8'h44, "R7");
    do_wr(16'h0301, 8'h55, "R7");
    do_jmp(16'h0300, "R7");
    do_fetch("R7 pc after jump");

    // Output enable holds until next transition, then drops (R9).
    do_rd(16'h0300, "R9");
    repeat (5) @(negedge clk);
    check8("R9 oe held", {7'b0, bus_oe}, 8'h01);
    check8("R9 data held", bus_out, 8'h44);
    strobe_edge(3'd1, 8'h00); set_exp(1'b0, 8'h00, 1'b1, "R9");
    check8("R9 oe drop", {7'b0, bus_oe}, 8'h00);
    strobe_edge(3'd0, 8'h00);
    strobe_edge(3'd0, 8'h66); mref[0] = 8'h66;
    do_rd(16'h0000, "R9 read after write");

    // Lines moving without strobe change nothing (R1).
    do_rd(16'h0001, "R1");
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      op_in = 3'(k); bus_in = 8'(k * 37 + 5);
      repeat (3) @(posedge clk);
    end
    check8("R1 oe unchanged", {7'b0, bus_oe}, 8'h01);
    check8("R1 data unchanged", bus_out, 8'h22);
    do_prd(8'hFE, "R1 sp unchanged");
    do_fetch("R1 pc unchanged");

    // Wrap and aliasing (R11).
    do_wr(16'hFFFF, 8'h9D, "R11");
    do_jmp(16'hFFFF, "R11 jump wrap");
    do_fetch("R11 pc wrapped");
    do_pwr(8'hFE, 8'h00, "R11");
    do_pwr(8'hFF, 8'h00, "R11");
    do_push(8'h6B, "R11 sp wrap");
    do_prd(8'hFF, "R11 sp high after wrap");
    do_rd(16'h03FF, "R11 alias");
    do_rd(16'h0400, "R11 alias");
    do_pop("R11 pop wrap");
    do_prd(8'hFF, "R11 sp back to zero");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule